// File: doc/BRIEF.md
# Machine State Register Move Unit

This block works out the next value of the 64-bit machine state register for the two move-to instructions. One is a narrow form that touches only the low word's fields. The other is a wide form that can also rewrite the upper fields. The block also serves the move-from instruction, which returns the current register value on a general result port. Bits are numbered big-endian: bit 0 is the most significant bit, so bit `b` sits at vector index `63-b`.

A request is presented for one cycle with `req_valid` high. It carries an operation code, the lightweight flag `req_l`, the current register value and the source operand. The results appear on the outputs in the next cycle, behind a single register stage. Privilege checks and interrupt generation belong to other logic. The write strobe tells the register file to take `msr_new`.

Top module: `msr_update_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `msr_we`, `gpr_we`, `msr_new` and `gpr_data` are all zero.
- R2: Results appear exactly one cycle after the request. A cycle with no request (`req_valid` low, or op 0) gives zero on both strobes and both data outputs. `msr_new` is zero whenever `msr_we` is low, and `gpr_data` is zero whenever `gpr_we` is low.
- R3: With `req_l`=1, both move-to forms take only bits 48 (interrupt enable) and 62 (recoverable) from the source. Every other bit keeps the current value.
- R4: With `req_l`=0, new bits 48, 58 and 59 each equal the source bit ORed with source bit 49 (problem state). When source bit 49 is set, all three are forced to 1.
- R5: The narrow form (op 1) with `req_l`=0 copies source bits 32–47, 49–50, 52–57 and 60–62. Bits 0–31, 51 and 63 keep the current value.
- R6: The wide form (op 2) with `req_l`=0 also copies source bits 0–2 and 4–28.
- R7: For the wide form with `req_l`=0, bits 29–31 take source bits 29–31. The exception is when the current bits 29–31 are 010 and the source bits 29–31 are 000: then the current value is kept.
- R8: Bits 3, 51 and 63 always keep their current value on every move-to.
- R9: Move-from (op 3) sets `gpr_we` and returns the current register unchanged on `gpr_data`, with `msr_we` low.
- R10: `msr_we` is high for both move-to forms (op 1 and op 2) and `gpr_we` is low for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 none, 1 narrow move-to, 2 wide move-to, 3 move-from |
| req_l | input | 1 | Lightweight flag: update only bits 48 and 62 |
| cur_msr | input | 64 | Current register value |
| rs_val | input | 64 | Source operand |
| msr_we | output | 1 | New register value is valid |
| msr_new | output | 64 | Next register value |
| gpr_we | output | 1 | Result port is valid |
| gpr_data | output | 64 | Move-from result |

## Verification
On every cycle, the assertions check several properties:
- the strobe coding for each operation
- that move-from returns the value unchanged
- that lightweight updates keep every bit other than 48 and 62
- that problem state forces bits 48, 58 and 59 high
- that bits 3, 51 and 63 are preserved
- the guard on bits 29–31

The exact copy ranges that separate the narrow form from the wide form are compared bit for bit only by the bench's reference model. So are the case where the guard does not fire and the all-zero outputs in idle cycles. The model is driven through directed corner cases and a long random run.

// File: rtl/msr_upd_pkg.sv
package msr_upd_pkg;

    localparam int XLEN = 64;
    localparam int OPW  = 2;

    typedef enum logic [OPW-1:0] {
        OPC_IDLE  = 2'd0,
        OPC_MT32  = 2'd1,
        OPC_MT64  = 2'd2,
        OPC_MFROM = 2'd3
    } msr_opc_e;

    // big-endian bit positions of fields with special rules
    localparam int B_EE    = 48;
    localparam int B_PR    = 49;
    localparam int B_IR    = 58;
    localparam int B_DR    = 59;
    localparam int B_RI    = 62;
    localparam int B_TS_LO = 29;
    localparam int B_TS_HI = 31;

    // vector index of a big-endian bit number
    function automatic int bix(input int b);
        return XLEN - 1 - b;
    endfunction

    // mask covering big-endian bits lo..hi inclusive
    function automatic logic [XLEN-1:0] span(input int lo, input int hi);
        logic [XLEN-1:0] m;
        m = '0;
        for (int b = lo; b <= hi; b++) m[bix(b)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/msr_copy_mask.sv
module msr_copy_mask
    import msr_upd_pkg::*;
(
    input  logic            wide,
    input  logic            lite,
    output logic [XLEN-1:0] copy_mask
);
    localparam logic [XLEN-1:0] M_LITE = span(B_EE, B_EE) | span(B_RI, B_RI);
    localparam logic [XLEN-1:0] M_LOW  = span(32, 47) | span(49, 50)
                                       | span(52, 57) | span(60, 62);
    localparam logic [XLEN-1:0] M_HIGH = span(0, 2) | span(4, 28);

    always_comb begin
        if (lite)      copy_mask = M_LITE;
        else if (wide) copy_mask = M_LOW | M_HIGH;
        else           copy_mask = M_LOW;
    end
endmodule

// File: rtl/msr_ts_guard.sv
module msr_ts_guard #(
    parameter int FW = 3
) (
    input  logic [FW-1:0] cur_f,
    input  logic [FW-1:0] src_f,
    output logic [FW-1:0] new_f
);
    localparam logic [FW-1:0] HOLD_CUR = FW'(2);
    localparam logic [FW-1:0] HOLD_SRC = '0;

    always_comb begin
        if ((cur_f == HOLD_CUR) && (src_f == HOLD_SRC)) new_f = cur_f;
        else                                             new_f = src_f;
    end
endmodule

// File: rtl/msr_move_core.sv
module msr_move_core
    import msr_upd_pkg::*;
(
    input  logic            wide,
    input  logic            lite,
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] rs_val,
    output logic [XLEN-1:0] nxt_msr
);
    localparam int TSW  = B_TS_HI - B_TS_LO + 1;
    localparam int TS_H = XLEN - 1 - B_TS_LO;
    localparam int TS_L = XLEN - 1 - B_TS_HI;
    localparam int NFORCE = 3;
    localparam int FORCE_BITS [NFORCE] = '{B_EE, B_IR, B_DR};

    logic [XLEN-1:0] copy_mask;
    logic [XLEN-1:0] merged;
    logic [TSW-1:0]  ts_new;
    logic            pr_src;

    msr_copy_mask u_mask (
        .wide      (wide),
        .lite      (lite),
        .copy_mask (copy_mask)
    );

    msr_ts_guard #(.FW(TSW)) u_ts (
        .cur_f (cur_msr[TS_H:TS_L]),
        .src_f (rs_val[TS_H:TS_L]),
        .new_f (ts_new)
    );

    assign pr_src = rs_val[bix(B_PR)];

    always_comb begin
        merged = (rs_val & copy_mask) | (cur_msr & ~copy_mask);
        if (!lite) begin
            for (int k = 0; k < NFORCE; k++)
                merged[bix(FORCE_BITS[k])] = rs_val[bix(FORCE_BITS[k])] | pr_src;
            if (wide) merged[TS_H:TS_L] = ts_new;
        end
        nxt_msr = merged;
    end
endmodule

// File: rtl/msr_update_unit.sv
module msr_update_unit
    import msr_upd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic            req_l,
    input  logic [63:0]     cur_msr,
    input  logic [63:0]     rs_val,
    output logic            msr_we,
    output logic [63:0]     msr_new,
    output logic            gpr_we,
    output logic [63:0]     gpr_data
);
    msr_opc_e        opc;
    logic            do_mt;
    logic            do_mf;
    logic [XLEN-1:0] nxt_msr;

    assign opc   = req_valid ? msr_opc_e'(req_op) : OPC_IDLE;

    always_comb begin
        do_mt = 1'b0;
        do_mf = 1'b0;
        unique case (opc)
            OPC_IDLE:  ;
            OPC_MT32,
            OPC_MT64:  do_mt = 1'b1;
            OPC_MFROM: do_mf = 1'b1;
            default:   ;
        endcase
    end

    msr_move_core u_core (
        .wide    (opc == OPC_MT64),
        .lite    (req_l),
        .cur_msr (cur_msr),
        .rs_val  (rs_val),
        .nxt_msr (nxt_msr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_we   <= 1'b0;
            gpr_we   <= 1'b0;
            msr_new  <= '0;
            gpr_data <= '0;
        end else begin
            msr_we   <= do_mt;
            gpr_we   <= do_mf;
            msr_new  <= do_mt ? nxt_msr : '0;
            gpr_data <= do_mf ? cur_msr : '0;
        end
    end
endmodule

// File: rtl/msr_update_chk.sv
module msr_update_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_op,
    input logic        req_l,
    input logic [63:0] cur_msr,
    input logic [63:0] rs_val,
    input logic        msr_we,
    input logic [63:0] msr_new,
    input logic        gpr_we,
    input logic [63:0] gpr_data
);
    localparam logic [63:0] KEEP_LITE = ~((64'd1 << 15) | (64'd1 << 1));
    localparam logic [63:0] KEEP_ALWAYS = (64'd1 << 60) | (64'd1 << 12) | 64'd1;

    logic mt_req;
    assign mt_req = req_valid && (req_op == 2'd1 || req_op == 2'd2);

    AST_MT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mt_req |=> (msr_we && !gpr_we)); // R10
    AST_MF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> (gpr_we && !msr_we && gpr_data == $past(cur_msr))); // R9
    AST_LITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_req && req_l) |=> ((msr_new & KEEP_LITE) == ($past(cur_msr) & KEEP_LITE))); // R3
    AST_PR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_req && !req_l && rs_val[14]) |=> (msr_new[15] && msr_new[5] && msr_new[4])); // R4
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        mt_req |=> ((msr_new & KEEP_ALWAYS) == ($past(cur_msr) & KEEP_ALWAYS))); // R8
    AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && !req_l && cur_msr[34:32] == 3'b010 && rs_val[34:32] == 3'b000)
        |=> (msr_new[34:32] == 3'b010)); // R7
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_we |-> (msr_new == 64'd0)); // R2
endmodule

bind msr_update_unit msr_update_chk u_chk (.*);

// File: tb/sim_msr_update_unit.sv
module sim_msr_update_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic        req_l;
    logic [63:0] cur_msr;
    logic [63:0] rs_val;
    logic        msr_we;
    logic [63:0] msr_new;
    logic        gpr_we;
    logic [63:0] gpr_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic        e_msr_we, e_gpr_we;
    logic [63:0] e_msr, e_gpr;
    string       e_tag;

    always #4 clk = ~clk;

    msr_update_unit u0 (.*);

    function automatic bit bitof(input logic [63:0] v, input int b);
        return v[63-b];
    endfunction

    function automatic logic [63:0] model(input logic [63:0] cur, input logic [63:0] rs,
                                          input bit wide, input bit l);
        logic [63:0] r;
        bit take;
        r = cur;
        for (int b = 0; b < 64; b++) begin
            if (l) begin
                if (b == 48 || b == 62) r[63-b] = bitof(rs, b);
            end else begin
                take = (b >= 32 && b <= 47) || b == 49 || b == 50 ||
                       (b >= 52 && b <= 57) || (b >= 60 && b <= 62);
                if (wide && (b <= 2 || (b >= 4 && b <= 28))) take = 1;
                if (take) r[63-b] = bitof(rs, b);
                if (b == 48 || b == 58 || b == 59) r[63-b] = bitof(rs, b) | bitof(rs, 49);
            end
        end
        if (wide && !l && !({bitof(cur,29),bitof(cur,30),bitof(cur,31)} == 3'b010 &&
                            {bitof(rs,29),bitof(rs,30),bitof(rs,31)} == 3'b000)) begin
            r[34] = bitof(rs, 29); r[33] = bitof(rs, 30); r[32] = bitof(rs, 31);
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge and check its result one cycle later
    task automatic step(input bit v, input logic [1:0] op, input bit l,
                        input logic [63:0] cur, input logic [63:0] rs);
        bit is_mt, is_mf;
        req_valid = v; req_op = op; req_l = l; cur_msr = cur; rs_val = rs;
        is_mt = v && (op == 2'd1 || op == 2'd2);
        is_mf = v && (op == 2'd3);
        e_msr_we = is_mt;
        e_gpr_we = is_mf;
        e_msr    = is_mt ? model(cur, rs, op == 2'd2, l) : 64'd0;
        e_gpr    = is_mf ? cur : 64'd0;
        if (is_mf)            e_tag = "R9";
        else if (!is_mt)      e_tag = "R2";
        else if (l)           e_tag = "R3";
        else if (op == 2'd1)  e_tag = "R5";
        else                  e_tag = "R6";
        @(negedge clk);
        chk({e_tag, "/R10 msr_we"}, 64'(msr_we), 64'(e_msr_we));
        chk({e_tag, " gpr_we"},     64'(gpr_we), 64'(e_gpr_we));
        chk({e_tag, " msr_new"},    msr_new, e_msr);
        chk({e_tag, " gpr_data"},   gpr_data, e_gpr);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] c, s;
        rst_n = 1'b0; req_valid = 0; req_op = 0; req_l = 0; cur_msr = 0; rs_val = 0;
        req_valid = 1; req_op = 2'd3; cur_msr = '1;
        repeat (3) @(negedge clk);
        // R1: outputs stay zero under reset even with a request present
        chk("R1 msr_we",  64'(msr_we), 0);
        chk("R1 gpr_we",  64'(gpr_we), 0);
        chk("R1 msr_new", msr_new, 0);
        chk("R1 gpr_data", gpr_data, 0);
        req_valid = 0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {62'd0, msr_we, gpr_we}, 0);

        // R3 lightweight, both forms
        step(1, 2'd1, 1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF);
        step(1, 2'd2, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        // R4 problem state forces 48/58/59
        s = 64'd1 << 14;
        step(1, 2'd1, 0, 64'h0, s);
        chk("R4 forced bits", {61'd0, msr_new[15], msr_new[5], msr_new[4]}, 64'd7);
        step(1, 2'd2, 0, 64'h0, 64'h0);
        chk("R4 no force", {61'd0, msr_new[15], msr_new[5], msr_new[4]}, 64'd0);
        // R5 narrow form leaves upper word alone
        step(1, 2'd1, 0, 64'hA5A5_A5A5_0000_0000, 64'h5A5A_5A5A_FFFF_FFFF);
        // R7 guard fires and does not fire
        c = 64'd1 << 33;  // bits 29..31 = 010
        step(1, 2'd2, 0, c, 64'h0);
        chk("R7 guard hold", 64'(msr_new[34:32]), 64'd2);
        step(1, 2'd2, 0, c, 64'd1 << 32);
        chk("R7 guard copy", 64'(msr_new[34:32]), 64'd1);
        step(1, 2'd1, 0, c, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7 narrow ignores", 64'(msr_new[34:32]), 64'd2);
        // R8 bits 3, 51, 63 kept
        step(1, 2'd2, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R8 kept zero", 64'({msr_new[60], msr_new[12], msr_new[0]}), 64'd0);
        step(1, 2'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        chk("R8 kept one", 64'({msr_new[60], msr_new[12], msr_new[0]}), 64'd7);
        // R9 move-from, R2 idle with op code or no valid
        step(1, 2'd3, 0, 64'hDEAD_BEEF_CAFE_F00D, 64'h1);
        step(1, 2'd0, 0, 64'hDEAD_BEEF_CAFE_F00D, 64'h1);
        step(0, 2'd2, 0, 64'hDEAD_BEEF_CAFE_F00D, 64'h1);

        for (int i = 0; i < 400; i++)
            step(1'($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)),
                 {$urandom, $urandom}, {$urandom, $urandom});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule